// File: doc/BRIEF.md
# Line Alarm Monitor with Sticky Interrupts

This block watches the alarm conditions of a line interface and presents them on a small register-read port. One byte gives the present state of every alarm. A second byte holds sticky interrupt flags, and reading it clears them. The alarms are line inactivity, receive loss of signal, loss of lock, a jitter-FIFO near-limit flag, analog and digital loss of signal, and a PRBS error flag. The line-inactivity alarm is produced inside the block. It counts bit periods in which neither rail of the bipolar line input carries a pulse.

The block also keeps a saturating count of PRBS errors, readable as two bytes and cleared by its own strobe. Four of the interrupt flags fire on every change of their alarm, whether it rises or falls. One fires on each PRBS error. One fires when the error count first reaches its maximum. Software polls the interrupt byte to learn what happened and then reads the status byte to see the present state. The read port is plain control: there is no handshake and no back-pressure. The read data is combinational from the address, and a strobe on the interrupt address clears the flags.

Top module: `line_alarm_monitor`

## Requirements
- R1: After reset, the status byte, the interrupt byte and the error count all read 0.
- R2: The status byte (address 1) is registered one cycle after its inputs. Bit positions: 0 line inactivity, 1 receive LOS, 2 loss of lock, 3 FIFO near-limit, 4 analog LOS, 5 digital LOS, 6 PRBS error. Bit 7 reads 0.
- R3: Interrupt bits 0 to 3 (address 0) follow the status bits 0 to 3. Each one sets on a rising or a falling change of its status bit, at the same clock edge as the status update.
- R4: Interrupt bit 4 sets in any cycle where the PRBS error input is high. Bits 6 and 7 read 0.
- R5: With `rd_en` high and `rd_addr` 0, the read data shows the interrupt byte from before the clear. The clear takes effect at the next clock edge.
- R6: If an interrupt bit is set and cleared by a read in the same cycle, the set wins and the bit stays 1.
- R7: Line inactivity asserts after IDLE_LIMIT bit periods (`bit_tick` strobes) with no pulse on either rail. It holds while the line stays quiet. A pulse on either rail restarts the count.
- R8: FIFO near-limit is 1 when `fifo_fill` <= FIFO_MARGIN or `fifo_fill` >= FIFO_DEPTH - FIFO_MARGIN.
- R9: The error count adds one per cycle with the PRBS error input high and holds at 2^CNT_W-1. Interrupt bit 5 sets only on the step into that maximum.
- R10: The error count reads at address 2 (bits 7:0) and address 3 (bits 15:8, with bits above CNT_W reading 0). The count returns to 0 one cycle after `err_cnt_clr`, and the clear has priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One strobe per line bit period |
| pulse_pos | input | 1 | Positive-rail pulse seen |
| pulse_neg | input | 1 | Negative-rail pulse seen |
| rx_los | input | 1 | Receive loss of signal |
| lock_lost | input | 1 | Clock recovery out of lock |
| analog_los | input | 1 | Analog loss of signal |
| digital_los | input | 1 | Digital loss of signal |
| prbs_err | input | 1 | PRBS bit error this cycle |
| fifo_fill | input | $clog2(FIFO_DEPTH+1) | Jitter FIFO fill level |
| err_cnt_clr | input | 1 | Clear the PRBS error count |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Register address |
| rd_data | output | 8 | Read data, combinational |

## Verification
The bench uses CNT_W = 6 and IDLE_LIMIT = 16, with FIFO_DEPTH = 16 and FIFO_MARGIN = 2. With these values the counter saturates after 63 errors and inactivity asserts after 16 bit periods. That lets the bench check the step into saturation, the hold at the maximum afterwards, and the exact edge where inactivity asserts, all within a few hundred cycles. The FIFO limits are probed on both sides of each threshold (fills 2, 3, 13 and 14).

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam logic [1:0] ADDR_IRQ    = 2'd0;
  localparam logic [1:0] ADDR_STAT   = 2'd1;
  localparam logic [1:0] ADDR_CNT_LO = 2'd2;
  localparam logic [1:0] ADDR_CNT_HI = 2'd3;

  localparam int STAT_W   = 7;
  localparam int IRQ_W    = 6;
  localparam int EDGE_W   = 4;  // status bits whose changes raise interrupts
  localparam int IRQ_PRBS = 4;
  localparam int IRQ_SAT  = 5;
endpackage

// File: rtl/lam_idle_detect.sv
module lam_idle_detect #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pulse_p,
  input  logic pulse_n,
  output logic idle
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic         pulse;

  assign pulse = pulse_p | pulse_n;
  assign idle  = (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (pulse)              cnt_q <= '0;
    else if (tick && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  // R7: a pulse on either rail clears the inactivity alarm
  a_r7_pulse_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !idle);
  // R7: alarm holds while the line stays quiet
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !pulse) |=> idle);
endmodule

// File: rtl/lam_err_counter.sv
module lam_err_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         sat_evt
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;
  assign cnt     = cnt_q;
  assign sat_evt = err && !clr && (cnt_q == MAX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (err && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  a_r9_sat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX && !clr) |=> cnt_q == MAX);
  a_r9_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/lam_irq_latch.sv
module lam_irq_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end

  // R6: a set is never lost to a simultaneous clear
  a_r6_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)));
  // R5: a clear with no set empties the register
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> q == '0);
endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor
  import lam_pkg::*;
#(
  parameter int IDLE_LIMIT  = 128,
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int FIFO_MARGIN = 2,
  localparam int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              pulse_pos,
  input  logic              pulse_neg,
  input  logic              rx_los,
  input  logic              lock_lost,
  input  logic              analog_los,
  input  logic              digital_los,
  input  logic              prbs_err,
  input  logic [FILL_W-1:0] fifo_fill,
  input  logic              err_cnt_clr,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data
);
  localparam logic [FILL_W-1:0] LO_LIM = FILL_W'(FIFO_MARGIN);
  localparam logic [FILL_W-1:0] HI_LIM = FILL_W'(FIFO_DEPTH - FIFO_MARGIN);

  logic              idle;
  logic              fifo_near;
  logic [STAT_W-1:0] live_stat, stat_q;
  logic [IRQ_W-1:0]  irq_set, irq_q;
  logic              irq_clr;
  logic [CNT_W-1:0]  err_cnt;
  logic [15:0]       cnt16;
  logic              sat_evt;

  lam_idle_detect #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick),
    .pulse_p(pulse_pos), .pulse_n(pulse_neg), .idle(idle)
  );

  lam_err_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .err(prbs_err), .clr(err_cnt_clr),
    .cnt(err_cnt), .sat_evt(sat_evt)
  );

  assign fifo_near = (fifo_fill <= LO_LIM) || (fifo_fill >= HI_LIM);
  assign live_stat = {prbs_err, digital_los, analog_los, fifo_near,
                      lock_lost, rx_los, idle};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= live_stat;
  end

  assign irq_set = {sat_evt, prbs_err, live_stat[EDGE_W-1:0] ^ stat_q[EDGE_W-1:0]};
  assign irq_clr = rd_en && (rd_addr == ADDR_IRQ);

  lam_irq_latch #(.N(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .q(irq_q)
  );

  assign cnt16 = 16'(err_cnt);

  always_comb begin
    unique case (rd_addr)
      ADDR_IRQ:    rd_data = 8'(irq_q);
      ADDR_STAT:   rd_data = 8'(stat_q);
      ADDR_CNT_LO: rd_data = cnt16[7:0];
      default:     rd_data = cnt16[15:8];
    endcase
  end

  // R3: a status change on bits 0..3 shows in the interrupt byte next cycle
  a_r3_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (live_stat[EDGE_W-1:0] != stat_q[EDGE_W-1:0]) |=>
      ((irq_q[EDGE_W-1:0] & $past(live_stat[EDGE_W-1:0] ^ stat_q[EDGE_W-1:0]))
        == $past(live_stat[EDGE_W-1:0] ^ stat_q[EDGE_W-1:0])));
  // R4: a PRBS error raises its interrupt bit
  a_r4_prbs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_err |=> irq_q[IRQ_PRBS]);
  // R9: saturation interrupt fires when the count steps into its maximum
  a_r9_sat_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '1 && !err_cnt_clr && prbs_err) ##1 (err_cnt == '1) |-> irq_q[IRQ_SAT]);
endmodule

// File: tb/test_line_alarm_monitor.sv
module test_line_alarm_monitor;
  localparam int FILL_W = $clog2(16 + 1);
  localparam int LIM    = 16;

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, pulse_pos = 0, pulse_neg = 0;
  logic rx_los = 0, lock_lost = 0, analog_los = 0, digital_los = 0, prbs_err = 0;
  logic [FILL_W-1:0] fifo_fill = 8;
  logic err_cnt_clr = 0, rd_en = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;

  int total = 0, fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  line_alarm_monitor #(.IDLE_LIMIT(LIM), .CNT_W(6), .FIFO_DEPTH(16), .FIFO_MARGIN(2))
  i_line_alarm_monitor (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pulse_pos(pulse_pos),
    .pulse_neg(pulse_neg), .rx_los(rx_los), .lock_lost(lock_lost),
    .analog_los(analog_los), .digital_los(digital_los), .prbs_err(prbs_err),
    .fifo_fill(fifo_fill), .err_cnt_clr(err_cnt_clr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a; #1; d = rd_data;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic t_reset;
    peek(2'd1, v); check("R1 status", v, 8'h00);
    peek(2'd0, v); check("R1 irq", v, 8'h00);
    peek(2'd2, v); check("R1 count", v, 8'h00);
  endtask

  task automatic t_status;
    rx_los = 1; analog_los = 1; tick();
    peek(2'd1, v); check("R2 layout a", v, 8'h12);
    lock_lost = 1; digital_los = 1; fifo_fill = 2; tick();
    peek(2'd1, v); check("R8 fill 2 near", v, 8'h3E);
    fifo_fill = 3; tick();
    peek(2'd1, v); check("R8 fill 3 clear", v, 8'h36);
    fifo_fill = 14; tick();
    peek(2'd1, v); check("R8 fill 14 near", v, 8'h3E);
    fifo_fill = 13; tick();
    peek(2'd1, v); check("R8 fill 13 clear", v, 8'h36);
    rx_los = 0; analog_los = 0; lock_lost = 0; digital_los = 0; fifo_fill = 8; tick();
    peek(2'd1, v); check("R2 all clear bit7 0", v, 8'h00);
    rd(2'd0, v); check("R3 bits 1..3 flagged", v, 8'h0E);
  endtask

  task automatic t_edges;
    lock_lost = 1; tick();
    rd(2'd0, v); check("R3 rise", v, 8'h04);
    rd(2'd0, v); check("R5 cleared after read", v, 8'h00);
    lock_lost = 0; tick();
    peek(2'd0, v); check("R3 fall", v, 8'h04);
    rd(2'd0, v); check("R5 pre-clear data", v, 8'h04);
    peek(2'd0, v); check("R5 clear next cycle", v, 8'h00);
  endtask

  task automatic t_set_wins;
    rx_los = 1;
    rd(2'd0, v); check("R6 read before set", v, 8'h00);
    rd(2'd0, v); check("R6 set kept", v, 8'h02);
    rd(2'd0, v); check("R6 then cleared", v, 8'h00);
    rx_los = 0; tick();
    rd(2'd0, v);
  endtask

  task automatic t_prbs;
    prbs_err = 1; tick();
    peek(2'd1, v); check("R2 prbs status", v, 8'h40);
    prbs_err = 0; tick();
    peek(2'd1, v); check("R2 prbs status drops", v, 8'h00);
    rd(2'd0, v); check("R4 prbs irq", v, 8'h10);
    peek(2'd2, v); check("R9 count one", v, 8'h01);
  endtask

  task automatic t_sat;
    prbs_err = 1; tick(61);
    peek(2'd2, v); check("R9 count 62", v, 8'd62);
    peek(2'd0, v); check("R9 no sat yet", v, 8'h10);
    tick();
    prbs_err = 0;
    peek(2'd2, v); check("R9 count max", v, 8'd63);
    rd(2'd0, v); check("R9 sat irq", v, 8'h30);
    prbs_err = 1; tick(5); prbs_err = 0;
    peek(2'd2, v); check("R9 holds at max", v, 8'd63);
    rd(2'd0, v); check("R9 sat irq once", v, 8'h10);
    peek(2'd3, v); check("R10 high byte", v, 8'h00);
    prbs_err = 1; err_cnt_clr = 1; tick(); err_cnt_clr = 0; prbs_err = 0;
    peek(2'd2, v); check("R10 clear wins", v, 8'h00);
    rd(2'd0, v);
  endtask

  task automatic t_idle;
    bit_tick = 1; pulse_pos = 1; tick(); pulse_pos = 0;
    tick(LIM);
    peek(2'd1, v); check("R7 not yet idle", v, 8'h00);
    tick();
    peek(2'd1, v); check("R7 idle asserts", v, 8'h01);
    tick(20);
    peek(2'd1, v); check("R7 idle holds", v, 8'h01);
    rd(2'd0, v); check("R7 idle irq", v, 8'h01);
    pulse_neg = 1; tick(); pulse_neg = 0;
    peek(2'd1, v); check("R7 status lags", v, 8'h01);
    tick();
    peek(2'd1, v); check("R7 neg rail restarts", v, 8'h00);
    rd(2'd0, v); check("R3 idle fall irq", v, 8'h01);
    bit_tick = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    t_reset();
    t_status();
    t_edges();
    t_set_wins();
    t_prbs();
    t_sat();
    t_idle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule